// File: doc/BRIEF.md
# Two-Wire Byte Transfer Engine

This block moves one byte at a time over a two-wire serial bus, either as the bus master or as an addressed slave. It is clocked by the system clock. It is told about the serial clock through single-cycle strobes for the rising and falling edges of SCL, and it reads the data line as an already-sampled level. It drives the data line only by asserting an open-drain pull-low request. Each byte takes nine serial clocks: eight data bits with the most significant bit first, then one acknowledge bit. The engine generates that acknowledge when it receives and samples it when it transmits.

The first byte after a START is a 7-bit calling address followed by a direction bit. As a slave, the engine compares the address with its own address. It answers only on a match, and it ignores the bus until the next START otherwise. After every byte that belongs to this node, the engine asks the surrounding logic to hold SCL low. The hold lasts until software writes the data register (transmit direction) or reads it (receive direction). The engine keeps the status flags software polls or takes interrupts from: byte complete, addressed as slave, arbitration lost, slave direction, interrupt pending and received acknowledge. The bus-busy indication from the START/STOP detector passes straight through. The clock divider and the START/STOP detectors sit outside this block.

Top module: `tw_byte_engine`

## Requirements
- R1: While transmitting, in each of the 8 data-bit slots `sda_low` is 1 exactly when the current bit of the loaded byte is 0, most significant bit first. In the ninth (acknowledge) slot a transmitter never pulls SDA low. `rx_byte` shows the 8 levels sampled at the rising edges, with the first sampled bit in bit 7.
- R2: The byte following `start_det` is an address byte. A slave (`master`=0) whose `own_addr` equals bits 7..1 of that byte pulls SDA low in the acknowledge slot. A slave whose address differs does not acknowledge, sets no flag, does not hold SCL, and ignores strobes until the next `start_det`.
- R3: `st_done` is 1 after reset. It clears at the first rising edge of a byte and at the release access (`data_rd` with `transmit`=0, `data_wr` with `transmit`=1). It sets on the falling edge that closes the ninth clock of a byte this node takes part in.
- R4: `st_irq` sets on each completed byte of this node (the address byte of a match included) and on arbitration loss. Only `irq_clr` clears it.
- R5: `st_aas` sets when a matching address byte completes and clears on any `ctrl_wr`. Data bytes do not set it.
- R6: On a matching address byte `st_srw` takes bit 0 of that byte (1 = master reads from this node). At any other time it keeps its value.
- R7: When transmitting, `st_rxak` takes the SDA level at the ninth rising edge (1 = no acknowledge). When receiving data, the engine pulls SDA low in the acknowledge slot only when `noack`=0.
- R8: After a completed byte of this node, `scl_hold` is 1 until the release access. The access of the other direction (for example `data_wr` while `transmit`=0) does not release it.
- R9: A master that sends a 1 and samples 0 on SDA sets `st_al` and `st_irq` and stops driving SDA for the rest of that byte. `al_clr` clears `st_al`.
- R10: `rstart` gives `rs_go`=1 only while `master`=1. A `rstart` while `master`=0 sets `st_al` instead.
- R11: After reset `st_done`=1, `st_rxak`=1, every other flag, `sda_low`, `scl_hold` and `rx_byte` are 0. `st_busy` always equals `bus_busy`.
- R12: With `en`=0 the bit counter, hold and drive are reset (`scl_hold`=0, `sda_low`=0), while the status flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable; 0 holds the shift state in reset |
| master | input | 1 | Master role selected |
| transmit | input | 1 | Transmit direction for data bytes |
| noack | input | 1 | 1 = send no acknowledge when receiving data |
| rstart | input | 1 | Repeated-start request strobe |
| ctrl_wr | input | 1 | Control register written |
| data_wr | input | 1 | Data register written |
| data_rd | input | 1 | Data register read |
| irq_clr | input | 1 | Software clears interrupt pending |
| al_clr | input | 1 | Software clears arbitration lost |
| tx_byte | input | DATA_W | Byte to transmit, loaded on data_wr while transmit=1 |
| own_addr | input | DATA_W-1 | This node's slave address |
| scl_rise | input | 1 | SCL rising-edge strobe |
| scl_fall | input | 1 | SCL falling-edge strobe |
| sda_in | input | 1 | Sampled SDA level |
| start_det | input | 1 | START or repeated START detected |
| bus_busy | input | 1 | Bus busy from the START/STOP detector |
| sda_low | output | 1 | Pull SDA low |
| scl_hold | output | 1 | Request to hold SCL low |
| rx_byte | output | DATA_W | Shift register contents / received byte |
| rs_go | output | 1 | Repeated start accepted |
| st_done | output | 1 | Byte complete flag |
| st_aas | output | 1 | Addressed-as-slave flag |
| st_busy | output | 1 | Bus busy flag |
| st_al | output | 1 | Arbitration lost flag |
| st_srw | output | 1 | Slave direction flag |
| st_irq | output | 1 | Interrupt pending flag |
| st_rxak | output | 1 | Received acknowledge flag |

## Verification
The assertions check on every cycle that the bit counter stays in range, that a held clock never coincides with a driven data line, and that the flags respond to their trigger events: completion sets done and interrupt, a control write clears the slave flag, arbitration loss silences SDA and sets its sticky flag, and a repeated start from a slave is treated as lost arbitration. Only the bench scenarios can show the data itself: the bit order on SDA, the received byte value, which address bytes earn an acknowledge, the acknowledge level chosen by `noack`, and the direction bit captured on a match. The same holds for the release of the SCL hold by the correct register access and for flags surviving a disable.

// File: rtl/twbe_pkg.sv
package twbe_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic done;
    logic aas;
    logic al;
    logic srw;
    logic irq;
    logic rxak;
  } twbe_flags_t;
endpackage

// File: rtl/twbe_seq.sv
// Bit sequencer: counts the nine SCL clocks of a byte and tracks the
// address phase and the wait-for-software state between bytes.
module twbe_seq #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LAST  = DATA_W + 1,
  localparam int unsigned CNT_W = $clog2(DATA_W + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start_det,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             release_i,
  input  logic             cont_i,
  output logic             active_o,
  output logic             addr_ph_o,
  output logic             waiting_o,
  output logic [CNT_W-1:0] bitn_o,
  output logic             ev_rise_o,
  output logic             ev_end_o
);
  logic             active_q, addr_q, wait_q;
  logic [CNT_W-1:0] bitn_q;
  logic             run;

  assign run       = active_q & ~wait_q & ~start_det;
  assign ev_rise_o = run & scl_rise & (bitn_q < CNT_W'(LAST));
  assign ev_end_o  = run & scl_fall & (bitn_q == CNT_W'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      addr_q   <= 1'b0;
      wait_q   <= 1'b0;
      bitn_q   <= '0;
    end else if (!en) begin
      active_q <= 1'b0;
      addr_q   <= 1'b0;
      wait_q   <= 1'b0;
      bitn_q   <= '0;
    end else if (start_det) begin
      active_q <= 1'b1;
      addr_q   <= 1'b1;
      wait_q   <= 1'b0;
      bitn_q   <= '0;
    end else if (wait_q && release_i) begin
      wait_q   <= 1'b0;
    end else if (ev_rise_o) begin
      bitn_q   <= bitn_q + 1'b1;
    end else if (ev_end_o) begin
      bitn_q   <= '0;
      addr_q   <= 1'b0;
      active_q <= cont_i;
      wait_q   <= cont_i;
    end
  end

  assign active_o  = active_q;
  assign addr_ph_o = addr_q;
  assign waiting_o = wait_q;
  assign bitn_o    = bitn_q;

  AST_BITN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bitn_q <= CNT_W'(LAST)); // R1
  AST_WAIT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q |-> (bitn_q == '0)); // R8
endmodule

// File: rtl/twbe_shift.sv
// Shift register, SDA drive, address compare and arbitration check.
module twbe_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W + 2),
  localparam int unsigned MSB   = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start_det,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              ev_rise,
  input  logic              ev_end,
  input  logic [CNT_W-1:0]  bitn,
  input  logic              active,
  input  logic              waiting,
  input  logic              addr_ph,
  input  logic              master,
  input  logic              transmit,
  input  logic              noack,
  input  logic              sda_in,
  output logic [DATA_W-1:0] sh_o,
  output logic              sda_low_o,
  output logic              hit_o,
  output logic              arb_o,
  output logic              tx_mode_o
);
  function automatic logic addr_match(input logic [DATA_W-1:0] frame,
                                      input logic [DATA_W-2:0] own);
    return frame[DATA_W-1:1] == own;
  endfunction

  logic [DATA_W-1:0] sh_q;
  logic              lost_q;
  logic              data_bit, ack_slot, ack_give;

  assign tx_mode_o = addr_ph ? master : transmit;
  assign data_bit  = bitn < CNT_W'(DATA_W);
  assign ack_slot  = bitn == CNT_W'(DATA_W);
  assign hit_o     = addr_ph & ~master & addr_match(sh_q, own_addr);
  assign ack_give  = addr_ph ? hit_o : ~noack;
  assign arb_o     = ev_rise & master & tx_mode_o & data_bit & sh_q[MSB]
                   & ~sda_in & ~lost_q;

  assign sda_low_o = active & ~waiting & ~lost_q &
                     ((tx_mode_o & data_bit & ~sh_q[MSB]) |
                      (~tx_mode_o & ack_slot & ack_give));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (load_i) begin
      sh_q <= tx_byte;
    end else if (ev_rise && data_bit) begin
      sh_q <= {sh_q[MSB-1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_q <= 1'b0;
    end else if (!en || start_det || ev_end) begin
      lost_q <= 1'b0;
    end else if (arb_o) begin
      lost_q <= 1'b1;
    end
  end

  assign sh_o = sh_q;

  AST_LOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    arb_o |=> !sda_low_o); // R9
endmodule

// File: rtl/twbe_flags.sv
// Status flags with their set and clear events.
module twbe_flags
  import twbe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_first,
  input  logic        ev_xfer,
  input  logic        ev_ackrise,
  input  logic        hit,
  input  logic        sh_lsb,
  input  logic        sda_in,
  input  logic        access,
  input  logic        arb,
  input  logic        ctrl_wr,
  input  logic        irq_clr,
  input  logic        al_clr,
  output twbe_flags_t flags_o
);
  twbe_flags_t f_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q <= '{done: 1'b1, aas: 1'b0, al: 1'b0, srw: 1'b0, irq: 1'b0, rxak: 1'b1};
    end else begin
      if (ev_xfer)                f_q.done <= 1'b1;
      else if (ev_first || access) f_q.done <= 1'b0;

      if (ev_xfer || arb)         f_q.irq <= 1'b1;
      else if (irq_clr)           f_q.irq <= 1'b0;

      if (arb)                    f_q.al <= 1'b1;
      else if (al_clr)            f_q.al <= 1'b0;

      if (ev_xfer && hit) begin
        f_q.aas <= 1'b1;
        f_q.srw <= sh_lsb;
      end else if (ctrl_wr) begin
        f_q.aas <= 1'b0;
      end

      if (ev_ackrise)             f_q.rxak <= sda_in;
    end
  end

  assign flags_o = f_q;

  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer |=> f_q.done); // R3
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_xfer || arb) |=> f_q.irq); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (f_q.irq && !irq_clr) |=> f_q.irq); // R4
  AST_AAS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !(ev_xfer && hit)) |=> !f_q.aas); // R5
  AST_AL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (f_q.al && !al_clr) |=> f_q.al); // R9
endmodule

// File: rtl/tw_byte_engine.sv
module tw_byte_engine
  import twbe_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W,
  localparam int unsigned CNT_W = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              master,
  input  logic              transmit,
  input  logic              noack,
  input  logic              rstart,
  input  logic              ctrl_wr,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              irq_clr,
  input  logic              al_clr,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  input  logic              start_det,
  input  logic              bus_busy,
  output logic              sda_low,
  output logic              scl_hold,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rs_go,
  output logic              st_done,
  output logic              st_aas,
  output logic              st_busy,
  output logic              st_al,
  output logic              st_srw,
  output logic              st_irq,
  output logic              st_rxak
);
  logic             active, addr_ph, waiting, ev_rise, ev_end;
  logic [CNT_W-1:0] bitn;
  logic [DATA_W-1:0] sh;
  logic             hit, arb_bit, tx_mode, cont;
  logic             access, load, ev_first, ev_ackrise, ev_xfer, rs_bad, arb_any;
  twbe_flags_t      flags;

  // Named internal events
  assign access     = transmit ? data_wr : data_rd;
  assign load       = data_wr & transmit;
  assign cont       = master | hit | ~addr_ph;
  assign ev_first   = ev_rise & (bitn == '0);
  assign ev_ackrise = ev_rise & (bitn == CNT_W'(DATA_W)) & tx_mode;
  assign ev_xfer    = ev_end & cont;
  assign rs_bad     = en & rstart & ~master;
  assign rs_go      = en & rstart & master;
  assign arb_any    = arb_bit | rs_bad;

  twbe_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .start_det(start_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .release_i(access), .cont_i(cont),
    .active_o(active), .addr_ph_o(addr_ph), .waiting_o(waiting), .bitn_o(bitn),
    .ev_rise_o(ev_rise), .ev_end_o(ev_end)
  );

  twbe_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(en), .start_det(start_det), .load_i(load),
    .tx_byte(tx_byte), .own_addr(own_addr), .ev_rise(ev_rise), .ev_end(ev_end),
    .bitn(bitn), .active(active), .waiting(waiting), .addr_ph(addr_ph),
    .master(master), .transmit(transmit), .noack(noack), .sda_in(sda_in),
    .sh_o(sh), .sda_low_o(sda_low), .hit_o(hit), .arb_o(arb_bit), .tx_mode_o(tx_mode)
  );

  twbe_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ev_first(ev_first), .ev_xfer(ev_xfer),
    .ev_ackrise(ev_ackrise), .hit(hit), .sh_lsb(sh[0]), .sda_in(sda_in),
    .access(access), .arb(arb_any), .ctrl_wr(ctrl_wr), .irq_clr(irq_clr),
    .al_clr(al_clr), .flags_o(flags)
  );

  assign scl_hold = waiting;
  assign rx_byte  = sh;
  assign st_done  = flags.done;
  assign st_aas   = flags.aas;
  assign st_busy  = bus_busy;
  assign st_al    = flags.al;
  assign st_srw   = flags.srw;
  assign st_irq   = flags.irq;
  assign st_rxak  = flags.rxak;

  AST_RS_FROM_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rstart && !master) |=> st_al); // R10
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> !sda_low); // R8
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scl_hold); // R12
endmodule

// File: tb/tw_byte_engine_test.sv
`timescale 1ns/1ps
module tw_byte_engine_test;
  logic clk = 1'b0;
  logic rst_n;
  logic en, master, transmit, noack, rstart, ctrl_wr, data_wr, data_rd;
  logic irq_clr, al_clr, scl_rise, scl_fall, sda_in, start_det, bus_busy;
  logic [7:0] tx_byte;
  logic [6:0] own_addr;
  logic sda_low, scl_hold, rs_go;
  logic st_done, st_aas, st_busy, st_al, st_srw, st_irq, st_rxak;
  logic [7:0] rx_byte;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tw_byte_engine uut (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .transmit(transmit),
    .noack(noack), .rstart(rstart), .ctrl_wr(ctrl_wr), .data_wr(data_wr),
    .data_rd(data_rd), .irq_clr(irq_clr), .al_clr(al_clr), .tx_byte(tx_byte),
    .own_addr(own_addr), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_in(sda_in), .start_det(start_det), .bus_busy(bus_busy),
    .sda_low(sda_low), .scl_hold(scl_hold), .rx_byte(rx_byte), .rs_go(rs_go),
    .st_done(st_done), .st_aas(st_aas), .st_busy(st_busy), .st_al(st_al),
    .st_srw(st_srw), .st_irq(st_irq), .st_rxak(st_rxak)
  );

  // {data, noack, expected ack drive}
  localparam logic [9:0] RX_VEC [4] = '{
    {8'hC3, 1'b0, 1'b1},
    {8'h00, 1'b1, 1'b0},
    {8'hFF, 1'b0, 1'b1},
    {8'h81, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rise(input logic b);
    sda_in = b; scl_rise = 1'b1; step(); scl_rise = 1'b0;
  endtask

  task automatic fall();
    scl_fall = 1'b1; step(); scl_fall = 1'b0;
  endtask

  task automatic pulse_start();
    start_det = 1'b1; step(); start_det = 1'b0;
  endtask

  task automatic shift_in(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      rise(b[i]); fall();
    end
  endtask

  task automatic shift_out(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      chk("R1 data bit drive", {7'd0, sda_low}, {7'd0, ~b[i]});
      rise(b[i]); fall();
    end
    chk("R1 ack slot released by transmitter", {7'd0, sda_low}, 8'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; en = 1; master = 0; transmit = 0; noack = 0; rstart = 0;
    ctrl_wr = 0; data_wr = 0; data_rd = 0; irq_clr = 0; al_clr = 0;
    scl_rise = 0; scl_fall = 0; sda_in = 1; start_det = 0; bus_busy = 0;
    tx_byte = 8'h00; own_addr = 7'h2A;
    repeat (3) step();
    rst_n = 1;
    step();

    // R11 reset state
    chk("R11 done", {7'd0, st_done}, 8'd1);
    chk("R11 rxak", {7'd0, st_rxak}, 8'd1);
    chk("R11 other flags", {3'd0, st_aas, st_al, st_srw, st_irq, scl_hold}, 8'd0);
    chk("R11 sda_low", {7'd0, sda_low}, 8'd0);
    chk("R11 rx_byte", rx_byte, 8'h00);
    bus_busy = 1; #1;
    chk("R11 busy passthrough", {7'd0, st_busy}, 8'd1);
    bus_busy = 0;

    // Slave receive, matching address, write direction
    pulse_start();
    shift_in(8'h54);
    chk("R3 done cleared in flight", {7'd0, st_done}, 8'd0);
    chk("R2 address ack", {7'd0, sda_low}, 8'd1);
    rise(1'b0); fall();
    chk("R3 done at ninth fall", {7'd0, st_done}, 8'd1);
    chk("R4 irq on match", {7'd0, st_irq}, 8'd1);
    chk("R5 aas on match", {7'd0, st_aas}, 8'd1);
    chk("R6 srw write", {7'd0, st_srw}, 8'd0);
    chk("R8 hold after byte", {7'd0, scl_hold}, 8'd1);
    chk("R1 address received", rx_byte, 8'h54);
    ctrl_wr = 1; step(); ctrl_wr = 0;
    chk("R5 aas cleared by ctrl write", {7'd0, st_aas}, 8'd0);
    chk("R4 irq kept over ctrl write", {7'd0, st_irq}, 8'd1);
    irq_clr = 1; step(); irq_clr = 0;
    chk("R4 irq cleared", {7'd0, st_irq}, 8'd0);
    data_wr = 1; step(); data_wr = 0;
    chk("R8 write does not release receiver", {7'd0, scl_hold}, 8'd1);

    // Table of slave data bytes
    for (int v = 0; v < 4; v++) begin
      noack = RX_VEC[v][1];
      data_rd = 1; step(); data_rd = 0;
      chk("R8 read releases hold", {7'd0, scl_hold}, 8'd0);
      chk("R3 done cleared by read", {7'd0, st_done}, 8'd0);
      shift_in(RX_VEC[v][9:2]);
      chk("R7 ack drive from noack", {7'd0, sda_low}, {7'd0, RX_VEC[v][0]});
      rise(RX_VEC[v][1]); fall();
      chk("R1 received byte", rx_byte, RX_VEC[v][9:2]);
      chk("R3 done after data byte", {7'd0, st_done}, 8'd1);
      chk("R4 irq after data byte", {7'd0, st_irq}, 8'd1);
      chk("R5 aas clear on data byte", {7'd0, st_aas}, 8'd0);
      chk("R8 hold after data byte", {7'd0, scl_hold}, 8'd1);
      irq_clr = 1; step(); irq_clr = 0;
    end
    noack = 0;

    // Address mismatch
    pulse_start();
    shift_in(8'h22);
    chk("R2 no ack on mismatch", {7'd0, sda_low}, 8'd0);
    rise(1'b1); fall();
    chk("R2 no hold on mismatch", {7'd0, scl_hold}, 8'd0);
    chk("R2 no irq on mismatch", {7'd0, st_irq}, 8'd0);
    chk("R2 no aas on mismatch", {7'd0, st_aas}, 8'd0);
    rise(1'b0); fall();
    chk("R2 ignored until start", {7'd0, scl_hold}, 8'd0);

    // Slave transmit
    pulse_start();
    shift_in(8'h55);
    chk("R2 ack read address", {7'd0, sda_low}, 8'd1);
    rise(1'b0); fall();
    chk("R6 srw read", {7'd0, st_srw}, 8'd1);
    chk("R5 aas on read address", {7'd0, st_aas}, 8'd1);
    transmit = 1;
    ctrl_wr = 1; step(); ctrl_wr = 0;
    irq_clr = 1; step(); irq_clr = 0;
    tx_byte = 8'hA5;
    data_wr = 1; step(); data_wr = 0;
    chk("R8 write releases transmitter", {7'd0, scl_hold}, 8'd0);
    chk("R3 done cleared by write", {7'd0, st_done}, 8'd0);
    shift_out(8'hA5);
    rise(1'b0); fall();
    chk("R7 rxak acknowledged", {7'd0, st_rxak}, 8'd0);
    tx_byte = 8'h3C;
    data_wr = 1; step(); data_wr = 0;
    shift_out(8'h3C);
    rise(1'b1); fall();
    chk("R7 rxak not acknowledged", {7'd0, st_rxak}, 8'd1);
    chk("R6 srw kept on data", {7'd0, st_srw}, 8'd1);

    // Master transmit of an address byte
    master = 1;
    irq_clr = 1; step(); irq_clr = 0;
    tx_byte = 8'hB4;
    data_wr = 1; step(); data_wr = 0;
    pulse_start();
    shift_out(8'hB4);
    rise(1'b0); fall();
    chk("R7 master rxak", {7'd0, st_rxak}, 8'd0);
    chk("R5 no aas as master", {7'd0, st_aas}, 8'd0);
    chk("R3 done master byte", {7'd0, st_done}, 8'd1);
    chk("R8 hold master", {7'd0, scl_hold}, 8'd1);

    // Arbitration loss
    irq_clr = 1; step(); irq_clr = 0;
    tx_byte = 8'h80;
    data_wr = 1; step(); data_wr = 0;
    chk("R1 first bit released", {7'd0, sda_low}, 8'd0);
    rise(1'b0);
    chk("R9 al set", {7'd0, st_al}, 8'd1);
    chk("R9 irq on loss", {7'd0, st_irq}, 8'd1);
    fall();
    chk("R9 drive stopped", {7'd0, sda_low}, 8'd0);
    al_clr = 1; step(); al_clr = 0;
    chk("R9 al cleared", {7'd0, st_al}, 8'd0);
    chk("R4 irq not cleared by al clear", {7'd0, st_irq}, 8'd1);

    // Repeated start
    rstart = 1; #1;
    chk("R10 rs_go as master", {7'd0, rs_go}, 8'd1);
    step(); rstart = 0;
    chk("R10 no al as master", {7'd0, st_al}, 8'd0);
    master = 0;
    rstart = 1; #1;
    chk("R10 no rs_go as slave", {7'd0, rs_go}, 8'd0);
    step(); rstart = 0;
    chk("R10 al from slave rstart", {7'd0, st_al}, 8'd1);
    al_clr = 1; step(); al_clr = 0;

    // Disable
    irq_clr = 1; step(); irq_clr = 0;
    transmit = 0;
    pulse_start();
    shift_in(8'h54);
    rise(1'b0); fall();
    chk("R12 hold before disable", {7'd0, scl_hold}, 8'd1);
    en = 0; step();
    chk("R12 hold reset", {7'd0, scl_hold}, 8'd0);
    chk("R12 drive reset", {7'd0, sda_low}, 8'd0);
    chk("R12 flags kept", {6'd0, st_aas, st_irq}, 8'd3);
    en = 1; step();
    chk("R12 stays idle", {7'd0, scl_hold}, 8'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule